// File: doc/BRIEF.md
# Sound Coprocessor Bus Control Block

This block sits on the main processor's synchronous bus and gives the main processor control over an 8-bit sound coprocessor. It decodes a 24-bit address, accepts byte or word writes and byte or word reads, and handles four regions:

- a run/halt (bus request) register;
- a write-only reset trigger;
- a 9-bit banking window register that is loaded one bit per write;
- a window into the coprocessor's local RAM.

RAM access is only open while the coprocessor is halted. Read data is registered and formatted to suit the access size.

Two small state machines hold the control state.

- **Run machine.** It has the states HALTED and ACTIVE. A bus-request write whose control bit is 1 takes the HALT transition, and one whose control bit is 0 takes the START transition. A write that matches the current state keeps the state, and nothing else moves it.
- **Reset pulser.** It has the states IDLE and PULSE. A reset write whose control bit is 0 takes the FIRE transition from IDLE to PULSE. The RELEASE transition always returns PULSE to IDLE one cycle later. A trigger that arrives while the pulser is in PULSE is absorbed.

The RAM is `2**RAM_AW` bytes. The full 8 KB part uses `RAM_AW = 13`, and the default build uses 11.

Top module: `cop_bus_ctrl`

## Requirements
- R1: After reset, `cop_run` is 0, `cop_bank` is 0, `cop_reset` is 0 and `bus_rdata` is 0x0000.
- R2: A write to address 0xA11100 takes its control bit from `bus_wdata[0]` on a byte write or from `bus_wdata[8]` on a word write. `cop_run` becomes the inverse of that bit from the next cycle on, so writing 1 halts the coprocessor. No other access changes `cop_run`.
- R3: A read of 0xA11100 returns a status byte with bit 7 set to 1, bit 0 equal to `cop_run`, and the other bits 0. A byte read places this byte in `bus_rdata[7:0]` with the upper byte 0. A word read places it in `bus_rdata[15:8]` with the lower byte 0.
- R4: A write to 0xA11200 whose control bit is 0 drives `cop_reset` high for exactly one cycle, starting in the cycle after the write. The control bit is taken from the same positions as in R2. A control bit of 1 gives no pulse, and reset writes leave `cop_run` unchanged.
- R5: A byte or word write whose address ANDed with 0xFF7F00 equals 0xA06000 shifts `cop_bank` right by one and loads `bus_wdata[0]` into bit 8. Other writes leave `cop_bank` unchanged.
- R6: While halted, a write to an address whose AND with 0xFF4000 equals 0xA00000 stores into RAM byte `addr[RAM_AW-1:0]`. A byte write stores `bus_wdata[7:0]` and a word write stores `bus_wdata[15:8]`.
- R7: While `cop_run` is 1, RAM reads return 0x0000 and RAM writes leave the memory unchanged.
- R8: A RAM read of either size while halted returns the stored byte in both halves of `bus_rdata`.
- R9: A read of any other address inside 0xA00000–0xA0FFFF returns 0xFFFF, and a read outside that window and outside the bus-request register returns 0x0000.
- R10: `bus_rdata` updates in the cycle after a read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_wr_byte | input | 1 | Byte write strobe |
| bus_wr_word | input | 1 | Word write strobe |
| bus_rd_byte | input | 1 | Byte read strobe |
| bus_rd_word | input | 1 | Word read strobe |
| bus_rdata | output | 16 | Registered read data |
| cop_run | output | 1 | 1 while the coprocessor runs |
| cop_reset | output | 1 | One-cycle reset pulse to the coprocessor |
| cop_bank | output | 9 | Banking window register |

## Verification
The bench goes after several corner cases, each of which a plausible mistake would get wrong.

- **Control-bit lanes.** It writes word and byte control values whose two candidate bits disagree. A design that took the bit from the wrong lane would halt when it should run.
- **Gated RAM.** It writes RAM while the coprocessor runs and then reads the same location after halting. A leaky gate would show the new byte instead of the old one.
- **Bank mirrors.** It writes the bank register through mirrored addresses and through a near-miss address. A loose mask would shift on the near miss, and a tight mask would miss the mirrors.
- **Reset trigger.** It checks both the width of the reset pulse and reset writes that must not pulse.
- **Readback.** It checks unmapped reads that must return all ones, and read data that must hold between reads.

// File: rtl/cop_pkg.sv
package cop_pkg;

    localparam logic [23:0] BUSREQ_ADDR = 24'hA11100;
    localparam logic [23:0] RSTREG_ADDR = 24'hA11200;
    localparam logic [23:0] BANK_MASK   = 24'hFF7F00;
    localparam logic [23:0] BANK_MATCH  = 24'hA06000;
    localparam logic [23:0] RAM_MASK    = 24'hFF4000;
    localparam logic [23:0] RAM_MATCH   = 24'hA00000;
    localparam logic [23:0] WIN_MASK    = 24'hFF0000;
    localparam logic [23:0] WIN_MATCH   = 24'hA00000;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_BUSREQ,
        RG_RSTREG,
        RG_BANK,
        RG_RAM,
        RG_WINDOW
    } region_e;

    typedef enum logic {
        RUN_HALTED,
        RUN_ACTIVE
    } run_state_e;

    typedef enum logic {
        PULSE_IDLE,
        PULSE_HIGH
    } pulse_state_e;

endpackage

// File: rtl/cop_addr_decode.sv
module cop_addr_decode
    import cop_pkg::*;
(
    input  logic [23:0] addr,
    output region_e     region
);
    always_comb begin
        if (addr == BUSREQ_ADDR)
            region = RG_BUSREQ;
        else if (addr == RSTREG_ADDR)
            region = RG_RSTREG;
        else if ((addr & BANK_MASK) == BANK_MATCH)
            region = RG_BANK;
        else if ((addr & RAM_MASK) == RAM_MATCH)
            region = RG_RAM;
        else if ((addr & WIN_MASK) == WIN_MATCH)
            region = RG_WINDOW;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/cop_run_fsm.sv
module cop_run_fsm
    import cop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic ctl_bit,
    output logic run
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALTED: if (req_wr && !ctl_bit) state_d = RUN_ACTIVE; // START
            RUN_ACTIVE: if (req_wr &&  ctl_bit) state_d = RUN_HALTED; // HALT
        endcase
    end

    always_comb begin
        unique case (state_q)
            RUN_HALTED: run = 1'b0;
            RUN_ACTIVE: run = 1'b1;
        endcase
    end

    a_r2_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req_wr |=> $stable(run));
    a_r2_run_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |=> (run == !$past(ctl_bit)));
endmodule

// File: rtl/cop_reset_pulse.sv
module cop_reset_pulse
    import cop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    pulse_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PULSE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PULSE_IDLE: if (trig) state_d = PULSE_HIGH; // FIRE
            PULSE_HIGH: state_d = PULSE_IDLE;           // RELEASE
        endcase
    end

    always_comb begin
        unique case (state_q)
            PULSE_IDLE: pulse = 1'b0;
            PULSE_HIGH: pulse = 1'b1;
        endcase
    end

    a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    a_r4_fires_after_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !pulse) |=> pulse);
endmodule

// File: rtl/cop_bank_shift.sv
module cop_bank_shift #(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [BANK_W-1:0] bank
);
    always_ff @(posedge clk) begin
        if (!rst_n)        bank <= '0;
        else if (shift_en) bank <= {din, bank[BANK_W-1:1]};
    end

    a_r5_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(bank));
    a_r5_bank_top_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (bank[BANK_W-1] == $past(din)));
endmodule

// File: rtl/cop_ram.sv
module cop_ram #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wbyte,
    output logic [7:0]    rbyte
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wbyte;
    end

    assign rbyte = mem[idx];
endmodule

// File: rtl/cop_bus_ctrl.sv
module cop_bus_ctrl
    import cop_pkg::*;
#(
    parameter int RAM_AW = 11,
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [23:0]       bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_wr_byte,
    input  logic              bus_wr_word,
    input  logic              bus_rd_byte,
    input  logic              bus_rd_word,
    output logic [15:0]       bus_rdata,
    output logic              cop_run,
    output logic              cop_reset,
    output logic [BANK_W-1:0] cop_bank
);
    region_e    region;
    logic       wr_any, rd_any, ctl_bit;
    logic [7:0] ram_rbyte, status_byte, ram_wbyte;

    assign wr_any  = bus_wr_byte | bus_wr_word;
    assign rd_any  = bus_rd_byte | bus_rd_word;
    assign ctl_bit = bus_wr_word ? bus_wdata[8] : bus_wdata[0];

    cop_addr_decode u_dec (
        .addr   (bus_addr),
        .region (region)
    );

    cop_run_fsm u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_wr  (wr_any && region == RG_BUSREQ),
        .ctl_bit (ctl_bit),
        .run     (cop_run)
    );

    cop_reset_pulse u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (wr_any && region == RG_RSTREG && !ctl_bit),
        .pulse (cop_reset)
    );

    cop_bank_shift #(.BANK_W(BANK_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (wr_any && region == RG_BANK),
        .din      (bus_wdata[0]),
        .bank     (cop_bank)
    );

    assign ram_wbyte = bus_wr_word ? bus_wdata[15:8] : bus_wdata[7:0];

    cop_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (wr_any && region == RG_RAM && !cop_run),
        .idx   (bus_addr[RAM_AW-1:0]),
        .wbyte (ram_wbyte),
        .rbyte (ram_rbyte)
    );

    assign status_byte = {1'b1, 6'b0, cop_run};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_any) begin
            case (region)
                RG_BUSREQ: bus_rdata <= bus_rd_word ? {status_byte, 8'h00}
                                                    : {8'h00, status_byte};
                RG_RAM:    bus_rdata <= cop_run ? 16'h0000 : {ram_rbyte, ram_rbyte};
                RG_BANK,
                RG_WINDOW: bus_rdata <= 16'hFFFF;
                default:   bus_rdata <= 16'h0000;
            endcase
        end
    end

    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> $stable(bus_rdata));
    a_r3_status_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_byte && bus_addr == BUSREQ_ADDR) |=> bus_rdata[7]);
    a_r7_busy_ram_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && region == RG_RAM && cop_run) |=> (bus_rdata == 16'h0000));
    a_r4_reset_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == RSTREG_ADDR) |=> $stable(cop_run));
endmodule

// File: tb/tb_cop_bus_ctrl.sv
module tb_cop_bus_ctrl;
    localparam int NV = 28;
    // op: 0 idle, 1 byte write, 2 word write, 3 byte read, 4 word read
    // fields: op, addr, wdata, expected rdata (reads only), expected run, expected bank
    localparam logic [68:0] VEC [NV] = '{
        {3'd1, 24'hA00010, 16'h005A, 16'h0000, 1'b0, 9'h000},
        {3'd3, 24'hA00010, 16'h0000, 16'h5A5A, 1'b0, 9'h000},
        {3'd2, 24'hA00020, 16'hC311, 16'h0000, 1'b0, 9'h000},
        {3'd4, 24'hA00020, 16'h0000, 16'hC3C3, 1'b0, 9'h000},
        {3'd3, 24'hA11100, 16'h0000, 16'h0080, 1'b0, 9'h000},
        {3'd2, 24'hA11100, 16'h0000, 16'h0000, 1'b1, 9'h000},
        {3'd4, 24'hA11100, 16'h0000, 16'h8100, 1'b1, 9'h000},
        {3'd3, 24'hA11100, 16'h0000, 16'h0081, 1'b1, 9'h000},
        {3'd1, 24'hA00010, 16'h0077, 16'h0000, 1'b1, 9'h000},
        {3'd3, 24'hA00010, 16'h0000, 16'h0000, 1'b1, 9'h000},
        {3'd2, 24'hA00020, 16'h9900, 16'h0000, 1'b1, 9'h000},
        {3'd1, 24'hA11100, 16'h0001, 16'h0000, 1'b0, 9'h000},
        {3'd3, 24'hA00010, 16'h0000, 16'h5A5A, 1'b0, 9'h000},
        {3'd4, 24'hA00020, 16'h0000, 16'hC3C3, 1'b0, 9'h000},
        {3'd2, 24'hA11100, 16'h0100, 16'h0000, 1'b0, 9'h000},
        {3'd1, 24'hA11100, 16'h00FE, 16'h0000, 1'b1, 9'h000},
        {3'd2, 24'hA11100, 16'h0001, 16'h0000, 1'b1, 9'h000},
        {3'd1, 24'hA11100, 16'h0001, 16'h0000, 1'b0, 9'h000},
        {3'd1, 24'hA06000, 16'h0001, 16'h0000, 1'b0, 9'h100},
        {3'd2, 24'hA06000, 16'h0000, 16'h0000, 1'b0, 9'h080},
        {3'd1, 24'hA06080, 16'h0001, 16'h0000, 1'b0, 9'h140},
        {3'd1, 24'hA0E000, 16'h00FF, 16'h0000, 1'b0, 9'h1A0},
        {3'd1, 24'hA06100, 16'h0001, 16'h0000, 1'b0, 9'h1A0},
        {3'd2, 24'hA06000, 16'h0001, 16'h0000, 1'b0, 9'h1D0},
        {3'd4, 24'hA04000, 16'h0000, 16'hFFFF, 1'b0, 9'h1D0},
        {3'd3, 24'hA06000, 16'h0000, 16'hFFFF, 1'b0, 9'h1D0},
        {3'd4, 24'hB00000, 16'h0000, 16'h0000, 1'b0, 9'h1D0},
        {3'd3, 24'hA00010, 16'h0000, 16'h5A5A, 1'b0, 9'h1D0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr_byte = 1'b0, bus_wr_word = 1'b0;
    logic        bus_rd_byte = 1'b0, bus_rd_word = 1'b0;
    logic [15:0] bus_rdata;
    logic        cop_run, cop_reset;
    logic [8:0]  cop_bank;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    cop_bus_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr_byte (bus_wr_byte),
        .bus_wr_word (bus_wr_word),
        .bus_rd_byte (bus_rd_byte),
        .bus_rd_word (bus_rd_word),
        .bus_rdata   (bus_rdata),
        .cop_run     (cop_run),
        .cop_reset   (cop_reset),
        .cop_bank    (cop_bank)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one access for one cycle; on return the registered results are visible
    task automatic do_op(input logic [2:0] op, input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr    = a;
        bus_wdata   = d;
        bus_wr_byte = (op == 3'd1);
        bus_wr_word = (op == 3'd2);
        bus_rd_byte = (op == 3'd3);
        bus_rd_word = (op == 3'd4);
        @(negedge clk);
        bus_wr_byte = 1'b0;
        bus_wr_word = 1'b0;
        bus_rd_byte = 1'b0;
        bus_rd_word = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 run",   {15'd0, cop_run},   16'd0);
        check("R1 bank",  {7'd0, cop_bank},   16'd0);
        check("R1 reset", {15'd0, cop_reset}, 16'd0);
        check("R1 rdata", bus_rdata,          16'd0);

        // vector table: R2 R3 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][68:66], VEC[i][65:42], VEC[i][41:26]);
            if (VEC[i][68:66] >= 3'd3)
                check($sformatf("R3/R7/R8/R9 rdata vec %0d", i), bus_rdata, VEC[i][25:10]);
            check($sformatf("R2 run vec %0d", i), {15'd0, cop_run}, {15'd0, VEC[i][9]});
            check($sformatf("R5 bank vec %0d", i), {7'd0, cop_bank}, {7'd0, VEC[i][8:0]});
        end

        // R10 read data holds across idle and write cycles
        do_op(3'd0, 24'hA11100, 16'h0000);
        check("R10 hold idle", bus_rdata, 16'h5A5A);
        do_op(3'd1, 24'hA00010, 16'h0033);
        check("R10 hold write", bus_rdata, 16'h5A5A);
        do_op(3'd3, 24'hA00010, 16'h0000);
        check("R6 byte rewrite", bus_rdata, 16'h3333);

        // R4 reset trigger: byte, control bit 0
        do_op(3'd1, 24'hA11200, 16'h0000);
        check("R4 pulse byte", {15'd0, cop_reset}, 16'd1);
        do_op(3'd0, 24'h000000, 16'h0000);
        check("R4 pulse one cycle", {15'd0, cop_reset}, 16'd0);
        // word with bit8 = 0 (bit0 = 1) pulses
        do_op(3'd2, 24'hA11200, 16'h0001);
        check("R4 pulse word", {15'd0, cop_reset}, 16'd1);
        do_op(3'd0, 24'h000000, 16'h0000);
        // word with bit8 = 1 does not pulse
        do_op(3'd2, 24'hA11200, 16'h0100);
        check("R4 no pulse word", {15'd0, cop_reset}, 16'd0);
        do_op(3'd1, 24'hA11200, 16'h0001);
        check("R4 no pulse byte", {15'd0, cop_reset}, 16'd0);
        check("R4 run unchanged", {15'd0, cop_run}, 16'd0);

        // R1 second reset clears run and bank
        do_op(3'd1, 24'hA11100, 16'h0000);
        check("R2 run set", {15'd0, cop_run}, 16'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 run after reset",  {15'd0, cop_run}, 16'd0);
        check("R1 bank after reset", {7'd0, cop_bank}, 16'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule